// File: doc/BRIEF.md
# Write-Protected Bytewide Static Memory

This block models a 2048-byte static memory, eight bits wide, with active-low chip-select, output-enable and write strobes. A host clock samples the strobes, and the bidirectional data bus appears as separate in, out and drive-enable ports. A write takes place during the time when chip-select and the write strobe are both low. The byte is stored on the cycle that this overlap ends. Reads drive the bus only after the address, chip-select and output-enable have each been held long enough. Each of these three access delays is a separate clock-cycle parameter.

A power-fail protect input freezes the part. While it is high, every strobe and data input is ignored, the bus stays undriven and an open write is dropped. Stored bytes survive both protect periods and reset. A sticky violation flag reports two kinds of misuse. One is an address that moves inside a write window. The other is a write strobe that falls again before the post-write recovery time has passed. In both cases the offending write does not happen.

Top module: `prot_sram`

## Requirements
- R1: The array holds 2048 bytes selected by the 11-bit `addr`. A byte written at any address, including 0x000 and 0x7FF, reads back unchanged.
- R2: `dOe` is 1 only while `ceN`=0, `oeN`=0 and `protect`=0. While `weN`=1, it also needs the access delays of R3. When `dOe`=0, `dOut` is 0x00. When `dOe`=1, `dOut` is the byte at `addr`.
- R3: Each input has an age, which is the number of consecutive rising edges at which it was sampled at its present value. For `ceN` and `oeN` the value is 0. A read drives only when the address age is at least `T_ADDR`, the chip-select age is at least `T_CE` and the output-enable age is at least `T_OE`. The slowest of the three decides.
- R4: The write window is open in every cycle with `ceN`=0 and `weN`=0, provided recovery has elapsed. It opens at whichever strobe falls later. The address is taken when the window opens. The stored byte is the `dIn` sampled in the last open cycle, and it is committed at the clock edge of the first cycle in which the window is closed.
- R5: If `addr` differs from the opening address in any later cycle of the same window, `violation` rises at that edge and the write is discarded.
- R6: After a write window closes, the window cannot reopen until `weN` has been sampled high on `T_REC` further edges. A `weN` fall inside that interval writes nothing and sets `violation`.
- R7: While `protect`=1, `dOe` is 0 and `dOut` is 0x00. A write window open when protect rises is aborted without storing. Strobe activity during protect stores nothing and does not set `violation`.
- R8: If the bus is being driven and `weN` falls while `ceN` and `oeN` stay low, `dOe` stays 1 for `T_ODW` cycles and then drops.
- R9: `violation` stays 1 until reset.
- R10: During and after reset, `dOe`=0, `dOut`=0x00 and `violation`=0. Reset leaves the array contents intact.
- R11: Array contents are unchanged by a protect period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ceN | input | 1 | Chip select, active low |
| oeN | input | 1 | Output enable, active low |
| weN | input | 1 | Write strobe, active low |
| protect | input | 1 | Power-fail protect, active high |
| addr | input | 11 | Byte address |
| dIn | input | 8 | Data from the bus |
| dOut | output | 8 | Data to the bus |
| dOe | output | 1 | Bus drive enable |
| violation | output | 1 | Sticky timing-misuse flag |

## Verification
The bench targets the following cases:

- **Which access delay governs.** Three reads each start with a different limiting delay. A design that used the wrong delay would drive a cycle early or a cycle late.
- **Window close.** It closes a window with chip-select instead of the write strobe and changes `dIn` mid-window. A design that captured data at the opening, or only on a strobe rise, would store the wrong byte or none.
- **Protect during a read and during an open write.** A design that let the abort commit anyway would corrupt a byte that is later read back.
- **Misuse.** An early strobe fall and a moving address are each followed by a read-back to show nothing was written. Reset is then used to show the flag was sticky until then.

// File: rtl/prot_sram_pkg.sv
`timescale 1ns/1ps
package prot_sram_pkg;
  localparam int ADDR_W = 11;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 1 << ADDR_W;

  // strobes from control to datapath
  typedef struct packed {
    logic              capture;  // window open: sample dIn
    logic              commit;   // window just closed cleanly
    logic              drive;    // bus driven this cycle
    logic [ADDR_W-1:0] wrAddr;   // address held at window opening
  } ramCtl_t;
endpackage

// File: rtl/prot_sram_age.sv
`timescale 1ns/1ps
// saturating count of consecutive edges on which 'run' was seen high
module prot_sram_age #(
  parameter int W           = 3,
  parameter bit RESTART_ONE = 1'b0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         run,
  output logic [W-1:0] age
);
  localparam logic [W-1:0] AGE_TOP = '1;
  localparam logic [W-1:0] AGE_RESTART = RESTART_ONE ? W'(1) : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       age <= '0;
    else if (run)    age <= (age == AGE_TOP) ? age : age + 1'b1;
    else             age <= AGE_RESTART;
  end
endmodule

// File: rtl/prot_sram_ctrl.sv
`timescale 1ns/1ps
module prot_sram_ctrl
  import prot_sram_pkg::*;
#(
  parameter int T_ADDR = 3,
  parameter int T_CE   = 2,
  parameter int T_OE   = 1,
  parameter int T_ODW  = 1,
  parameter int T_REC  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic              protect,
  input  logic [ADDR_W-1:0] addr,
  output ramCtl_t           ctl,
  output logic              violation
);
  localparam int T_M1   = (T_ADDR > T_CE) ? T_ADDR : T_CE;
  localparam int T_M2   = (T_M1 > T_OE) ? T_M1 : T_OE;
  localparam int T_MAX  = (T_M2 > T_ODW) ? T_M2 : T_ODW;
  localparam int AGE_W  = $clog2(T_MAX + 2);
  localparam int REC_W  = $clog2(T_REC + 2);
  localparam int NAGE   = 4;
  localparam int A_ADDR = 0;
  localparam int A_CE   = 1;
  localparam int A_OE   = 2;
  localparam int A_WE   = 3;

  logic              weNPrev, winPrev, wasDriving, addrBad;
  logic [ADDR_W-1:0] addrPrev, addrHold;
  logic [REC_W-1:0]  recCnt;
  logic [NAGE-1:0]   runVec;
  logic [AGE_W-1:0]  age [NAGE];

  // input ages: address restarts at one on a change, strobes at zero when high
  assign runVec = {!weN, !oeN, !ceN, addr == addrPrev};

  for (genvar g = 0; g < NAGE; g++) begin : gAge
    prot_sram_age #(.W(AGE_W), .RESTART_ONE(g == A_ADDR)) uAge (
      .clk  (clk),
      .rstN (rstN),
      .run  (runVec[g]),
      .age  (age[g])
    );
  end

  logic weFall, recBusy, winNow, closing, ageOk, readBase, driveNow, addrMove;

  always_comb begin
    weFall   = weNPrev && !weN;
    recBusy  = recCnt != '0;
    winNow   = !ceN && !weN && !protect && !recBusy;
    closing  = winPrev && !winNow;
    addrMove = winNow && winPrev && (addr != addrHold);
    ageOk    = (addr == addrPrev)
            && (age[A_ADDR] >= AGE_W'(T_ADDR))
            && (age[A_CE]   >= AGE_W'(T_CE))
            && (age[A_OE]   >= AGE_W'(T_OE));
    readBase = !ceN && !oeN && !protect;
    driveNow = readBase && (weN ? ageOk
                                : (wasDriving && (age[A_WE] < AGE_W'(T_ODW))));
    ctl.capture = winNow;
    ctl.commit  = closing && !protect && !addrBad;
    ctl.drive   = driveNow;
    ctl.wrAddr  = addrHold;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      weNPrev    <= 1'b1;
      winPrev    <= 1'b0;
      addrPrev   <= '0;
      addrHold   <= '0;
      addrBad    <= 1'b0;
      wasDriving <= 1'b0;
      recCnt     <= '0;
      violation  <= 1'b0;
    end else begin
      weNPrev  <= weN;
      winPrev  <= winNow;
      addrPrev <= addr;
      if (weN) wasDriving <= driveNow;
      if (winNow && !winPrev) begin
        addrHold <= addr;
        addrBad  <= 1'b0;
      end else if (addrMove) begin
        addrBad  <= 1'b1;
      end
      if (closing && !protect)  recCnt <= REC_W'(T_REC);
      else if (weN && recBusy)  recCnt <= recCnt - 1'b1;
      if (addrMove || (weFall && recBusy && !protect)) violation <= 1'b1;
    end
  end

  AST_PROTECT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    protect |-> !ctl.drive); // R7
  AST_DRIVE_STROBES: assert property (@(posedge clk) disable iff (!rstN)
    ctl.drive |-> (!ceN && !oeN)); // R2
  AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    violation |=> violation); // R9
  AST_REC_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (!weN && recBusy && !closing) |=> (recCnt == $past(recCnt))); // R6
endmodule

// File: rtl/prot_sram_dpath.sv
`timescale 1ns/1ps
module prot_sram_dpath
  import prot_sram_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ramCtl_t           ctl,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dIn,
  output logic [DATA_W-1:0] dOut,
  output logic              dOe
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] dataHold;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            dataHold <= '0;
    else if (ctl.capture) dataHold <= dIn;
  end

  always_ff @(posedge clk) begin
    if (ctl.commit) mem[ctl.wrAddr] <= dataHold;
  end

  assign dOe  = ctl.drive;
  assign dOut = ctl.drive ? mem[addr] : '0;

  AST_COMMIT_AFTER_OPEN: assert property (@(posedge clk) disable iff (!rstN)
    ctl.commit |-> $past(ctl.capture)); // R4
endmodule

// File: rtl/prot_sram.sv
`timescale 1ns/1ps
module prot_sram
  import prot_sram_pkg::*;
#(
  parameter int T_ADDR = 3,
  parameter int T_CE   = 2,
  parameter int T_OE   = 1,
  parameter int T_ODW  = 1,
  parameter int T_REC  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic              protect,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dIn,
  output logic [DATA_W-1:0] dOut,
  output logic              dOe,
  output logic              violation
);
  ramCtl_t ctl;

  prot_sram_ctrl #(
    .T_ADDR(T_ADDR), .T_CE(T_CE), .T_OE(T_OE), .T_ODW(T_ODW), .T_REC(T_REC)
  ) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .ceN       (ceN),
    .oeN       (oeN),
    .weN       (weN),
    .protect   (protect),
    .addr      (addr),
    .ctl       (ctl),
    .violation (violation)
  );

  prot_sram_dpath uDpath (
    .clk  (clk),
    .rstN (rstN),
    .ctl  (ctl),
    .addr (addr),
    .dIn  (dIn),
    .dOut (dOut),
    .dOe  (dOe)
  );

  AST_PROTECT_HIZ: assert property (@(posedge clk) disable iff (!rstN)
    protect |-> (!dOe && dOut == '0)); // R7
endmodule

// File: tb/sim_prot_sram.sv
`timescale 1ns/1ps
module sim_prot_sram;
  localparam int F_OE = 0, F_DOUT = 1, F_VIOL = 2;

  logic        clk = 1'b0, rstN = 1'b0;
  logic        ceN = 1'b1, oeN = 1'b1, weN = 1'b1, protect = 1'b0;
  logic [10:0] addr = '0, curA = '0;
  logic [7:0]  dIn = '0;
  logic [7:0]  dOut;
  logic        dOe, violation;

  int    qField[$];
  logic [7:0] qVal[$];
  string qTag[$];
  int    errors = 0, checks = 0;
  bit    done = 1'b0;

  always #10 clk = ~clk;

  prot_sram u0 (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN), .protect(protect),
    .addr(addr), .dIn(dIn), .dOut(dOut), .dOe(dOe), .violation(violation)
  );

  task automatic drive(input logic ce, input logic oe, input logic we,
                       input logic [10:0] a, input logic [7:0] d, input logic p);
    @(negedge clk);
    ceN = ce; oeN = oe; weN = we; addr = a; dIn = d; protect = p; curA = a;
  endtask

  task automatic expectOn(input int f, input logic [7:0] v, input string tag);
    qField.push_back(f); qVal.push_back(v); qTag.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1, 1, 1, curA, 8'h00, 0);
  endtask

  task automatic writeByte(input logic [10:0] a, input logic [7:0] d);
    drive(0, 1, 1, a, d, 0);
    drive(0, 1, 0, a, d, 0);
    drive(0, 1, 0, a, d, 0);
    drive(0, 1, 1, a, d, 0);
    idle(3);
  endtask

  task automatic readCheck(input logic [10:0] a, input logic [7:0] d, input string tag);
    for (int i = 0; i < 3; i++) drive(0, 0, 1, a, 8'h00, 0);
    drive(0, 0, 1, a, 8'h00, 0);
    expectOn(F_OE, 8'h01, tag);
    expectOn(F_DOUT, d, tag);
    idle(1);
  endtask

  // monitor: compares queued expectations mid-cycle
  initial begin
    forever begin
      @(negedge clk);
      #5;
      while (qField.size() != 0) begin
        int f;
        logic [7:0] v, act;
        string t;
        f = qField.pop_front(); v = qVal.pop_front(); t = qTag.pop_front();
        case (f)
          F_OE:    act = {7'b0, dOe};
          F_DOUT:  act = dOut;
          default: act = {7'b0, violation};
        endcase
        checks++;
        if (act !== v) begin
          errors++;
          $display("FAIL %s field=%0d actual=%0h expected=%0h", t, f, act, v);
        end
      end
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R10 reset state
    drive(1, 1, 1, 11'h000, 8'h00, 0);
    expectOn(F_OE, 8'h00, "R10"); expectOn(F_VIOL, 8'h00, "R10");
    drive(1, 0, 1, 11'h000, 8'h00, 0);
    expectOn(F_DOUT, 8'h00, "R10");
    @(negedge clk); rstN = 1'b1;
    idle(2);

    writeByte(11'h005, 8'hA5);
    writeByte(11'h7FF, 8'h3C);
    writeByte(11'h000, 8'h11);

    // R3 address-limited read (all change together), R1 top address
    drive(0, 0, 1, 11'h7FF, 8'h00, 0); expectOn(F_OE, 8'h00, "R3");
    drive(0, 0, 1, 11'h7FF, 8'h00, 0);
    drive(0, 0, 1, 11'h7FF, 8'h00, 0); expectOn(F_OE, 8'h00, "R3");
    drive(0, 0, 1, 11'h7FF, 8'h00, 0);
    expectOn(F_OE, 8'h01, "R3"); expectOn(F_DOUT, 8'h3C, "R1");

    // R2 chip select high, then R3 chip-select-limited read
    drive(1, 1, 1, 11'h7FF, 8'h00, 0);
    expectOn(F_OE, 8'h00, "R2"); expectOn(F_DOUT, 8'h00, "R2");
    drive(1, 1, 1, 11'h7FF, 8'h00, 0);
    drive(1, 1, 1, 11'h7FF, 8'h00, 0);
    drive(0, 0, 1, 11'h7FF, 8'h00, 0);
    drive(0, 0, 1, 11'h7FF, 8'h00, 0); expectOn(F_OE, 8'h00, "R3");
    drive(0, 0, 1, 11'h7FF, 8'h00, 0);
    expectOn(F_OE, 8'h01, "R3"); expectOn(F_DOUT, 8'h3C, "R3");

    // R2 output enable high, then R3 output-enable-limited read
    drive(0, 1, 1, 11'h7FF, 8'h00, 0); expectOn(F_OE, 8'h00, "R2");
    drive(0, 1, 1, 11'h7FF, 8'h00, 0);
    drive(0, 0, 1, 11'h7FF, 8'h00, 0); expectOn(F_OE, 8'h00, "R3");
    drive(0, 0, 1, 11'h7FF, 8'h00, 0);
    expectOn(F_OE, 8'h01, "R3"); expectOn(F_DOUT, 8'h3C, "R3");

    // R8 write strobe falls during a read
    drive(0, 0, 0, 11'h7FF, 8'h3C, 0);
    expectOn(F_OE, 8'h01, "R8"); expectOn(F_DOUT, 8'h3C, "R8");
    drive(0, 0, 0, 11'h7FF, 8'h3C, 0); expectOn(F_OE, 8'h00, "R8");
    drive(0, 0, 1, 11'h7FF, 8'h3C, 0);
    idle(4);

    // R4 window closed by chip select, data changed mid-window
    drive(1, 1, 0, 11'h123, 8'h00, 0);
    drive(0, 1, 0, 11'h123, 8'h11, 0);
    drive(0, 1, 0, 11'h123, 8'h22, 0);
    drive(1, 1, 0, 11'h123, 8'h00, 0);
    idle(4);
    readCheck(11'h123, 8'h22, "R4");

    // R7 protect during a read
    for (int i = 0; i < 4; i++) drive(0, 0, 1, 11'h005, 8'h00, 0);
    expectOn(F_OE, 8'h01, "R7"); expectOn(F_DOUT, 8'hA5, "R7");
    drive(0, 0, 1, 11'h005, 8'h00, 1);
    expectOn(F_OE, 8'h00, "R7"); expectOn(F_DOUT, 8'h00, "R7");
    drive(0, 0, 1, 11'h005, 8'h00, 0); expectOn(F_OE, 8'h01, "R7");
    idle(2);

    // R7 protect aborts an open write, strobes ignored; R11 contents persist
    drive(0, 1, 0, 11'h005, 8'hEE, 0);
    drive(0, 1, 0, 11'h005, 8'hEE, 1);
    drive(1, 1, 1, 11'h005, 8'h00, 1);
    drive(0, 1, 0, 11'h005, 8'h77, 1);
    drive(1, 1, 1, 11'h005, 8'h00, 1);
    drive(1, 1, 1, 11'h005, 8'h00, 0); expectOn(F_VIOL, 8'h00, "R7");
    idle(3);
    readCheck(11'h005, 8'hA5, "R11");

    // R6 strobe falls inside recovery
    drive(0, 1, 1, 11'h200, 8'h5A, 0);
    drive(0, 1, 0, 11'h200, 8'h5A, 0);
    drive(0, 1, 1, 11'h200, 8'h5A, 0);
    drive(0, 1, 0, 11'h200, 8'h99, 0); expectOn(F_VIOL, 8'h00, "R6");
    drive(0, 1, 0, 11'h200, 8'h99, 0); expectOn(F_VIOL, 8'h01, "R6");
    drive(0, 1, 1, 11'h200, 8'h99, 0);
    idle(4);
    readCheck(11'h200, 8'h5A, "R6");
    idle(5);
    drive(1, 1, 1, 11'h200, 8'h00, 0); expectOn(F_VIOL, 8'h01, "R9");

    // R10 reset clears flag, keeps contents
    @(negedge clk); rstN = 1'b0;
    drive(1, 1, 1, 11'h200, 8'h00, 0); expectOn(F_VIOL, 8'h00, "R10");
    @(negedge clk); rstN = 1'b1;
    idle(2);
    readCheck(11'h7FF, 8'h3C, "R10");

    // R5 address moves inside a window
    writeByte(11'h300, 8'h01);
    writeByte(11'h301, 8'h02);
    drive(0, 1, 1, 11'h300, 8'h44, 0);
    drive(0, 1, 0, 11'h300, 8'h44, 0);
    drive(0, 1, 0, 11'h301, 8'h44, 0); expectOn(F_VIOL, 8'h00, "R5");
    drive(0, 1, 1, 11'h301, 8'h44, 0); expectOn(F_VIOL, 8'h01, "R5");
    idle(4);
    readCheck(11'h300, 8'h01, "R5");
    readCheck(11'h301, 8'h02, "R5");

    idle(2);
    @(negedge clk); #8;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule